// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block connects an on-chip core request port to an asynchronous external memory bus with 16-bit address and data. When the core raises a request, the block runs one external access. The access reaches either program space or data space, and each space has its own active-low select. The access is either a read or a write, with active-low read and write enables to match.

Every access has three phases:

- An address setup cycle.
- A strobe phase, which lasts one base cycle plus a wait-state count. The count is chosen per access from 0, 4, 8 or 12 by a 2-bit configuration input.
- A hold cycle, in which the enables are high again but the address and the write data are still driven.

The data pins are modelled as separate output, output-enable and input signals, so the pad ring can build the bidirectional driver. The output enable is low whenever no write is in progress. On reads, the value on the pins is captured at the clock edge where the read enable returns high. The core sees a one-cycle ready pulse when the access completes.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, both space selects and both enables are high, `bus_dq_oe` is 0, `core_ready` is 0 and `core_rdata` is 0.
- R2: The number of wait states is `cfg_ws`×4, so codes 0,1,2,3 give 0,4,8,12. The read or write enable stays low for exactly 1+WS consecutive cycles.
- R3: `core_space`=1 selects program space, so `bus_prog_n` is low and `bus_data_n` is high. `core_space`=0 selects data space, giving the reverse. The two selects are never low together.
- R4: The first cycle after acceptance is a setup cycle: the space select is low, both enables are high and `bus_addr` is valid. The cycle after the strobe phase is a hold cycle: the enables are high and the select and address are unchanged. `bus_addr` is stable for as long as a select is low.
- R5: During a read, `bus_dq_oe` stays 0. `core_rdata` takes the `bus_dq_i` value present in the last strobe cycle. A change on the pins after the read enable rises is not captured.
- R6: During a write, `bus_dq_oe` is 1 and `bus_dq_o` equals the write data from the setup cycle through the hold cycle.
- R7: With both space selects high, `bus_dq_oe` is 0.
- R8: The read enable goes low only for reads and the write enable only for writes. The two are never low together.
- R9: `core_ready` is high for exactly one cycle. It is high during the (4+WS)-th cycle after the accepting edge, with both selects already high. `core_rdata` keeps its value until the next read completes.
- R10: A request is taken only when the block is idle and `core_ready` is low. Changes on `core_addr`, `core_wdata` and `core_req` during an access do not alter the bus. A request held high through the ready cycle starts its access one cycle later.
- R11: `cfg_ws` is sampled when a request is accepted. Changing it during an access does not alter that access's strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ws | input | 2 | Wait-state code, WS = code×4 |
| core_req | input | 1 | Access request |
| core_we | input | 1 | 1 = write, 0 = read |
| core_space | input | 1 | 1 = program space, 0 = data space |
| core_addr | input | 16 | Access address |
| core_wdata | input | 16 | Write data |
| core_ready | output | 1 | One-cycle completion pulse |
| core_rdata | output | 16 | Last captured read data |
| bus_addr | output | 16 | External address |
| bus_prog_n | output | 1 | Program-space select, active low |
| bus_data_n | output | 1 | Data-space select, active low |
| bus_rd_n | output | 1 | Read enable, active low |
| bus_wr_n | output | 1 | Write enable, active low |
| bus_dq_o | output | 16 | Data driven to the pins |
| bus_dq_oe | output | 1 | Data pin output enable |
| bus_dq_i | input | 16 | Data read from the pins |

## Verification
Number the cycles from the accepting edge. The expected bus state is then fixed for each one:
- cycle 1 is setup;
- cycles 2 to 2+WS are strobe;
- cycle 3+WS is hold;
- cycle 4+WS carries `core_ready` and the captured read data.

The bench drives at the falling edge and samples every one of these cycles at the falling edge, so each result is read one half-period after the register that produces it. During an access it perturbs the address, write data, wait code and pin data at chosen cycles. This shows that only the latched values and the last-strobe-cycle pin value reach the bus and `core_rdata`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } xbus_phase_e;

   typedef enum logic {
      SPACE_DATA = 1'b0,
      SPACE_PROG = 1'b1
   } xbus_space_e;
endpackage

// File: rtl/xbus_waitgen.sv
module xbus_waitgen #(
   parameter int CFG_W   = 2,
   parameter int WS_STEP = 4,
   parameter int CNT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [CFG_W-1:0] cfg,
   output logic             last
);
   localparam bit STEP_POW2 = ((WS_STEP & (WS_STEP - 1)) == 0);
   localparam int SHIFT     = (WS_STEP > 1) ? $clog2(WS_STEP) : 0;

   logic [CNT_W-1:0] ws_val;
   logic [CNT_W-1:0] cnt_q;

   // wait-state decode: shift when the step is a power of two, else multiply
   generate
      if (STEP_POW2) begin : g_shift
         assign ws_val = CNT_W'(cfg) << SHIFT;
      end else begin : g_mult
         assign ws_val = CNT_W'(int'(cfg) * WS_STEP);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= ws_val;
      end else if (step && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

   AST_WAIT_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !last) |=> (cnt_q < $past(cnt_q))); // R2
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int CFG_W   = 2,
   parameter int WS_STEP = 4,
   parameter int CNT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  logic             space,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic [CFG_W-1:0] cfg,
   input  logic             wait_last,
   output xbus_phase_e      phase,
   output logic             acc_we,
   output xbus_space_e      acc_space,
   output logic [AW-1:0]    acc_addr,
   output logic [DW-1:0]    acc_wdata,
   output logic [CFG_W-1:0] acc_cfg,
   output logic             ready
);
   xbus_phase_e phase_q;
   logic        accept;

   assign accept = (phase_q == PH_IDLE) && req && !ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         acc_we    <= 1'b0;
         acc_space <= SPACE_DATA;
         acc_addr  <= '0;
         acc_wdata <= '0;
         acc_cfg   <= '0;
         ready     <= 1'b0;
      end else begin
         ready <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  acc_we    <= we;
                  acc_space <= xbus_space_e'(space);
                  acc_addr  <= addr;
                  acc_wdata <= wdata;
                  acc_cfg   <= cfg;
                  phase_q   <= PH_SETUP;
               end
            end
            PH_SETUP:  phase_q <= PH_STROBE;
            PH_STROBE: if (wait_last) phase_q <= PH_HOLD;
            PH_HOLD: begin
               phase_q <= PH_IDLE;
               ready   <= 1'b1;
            end
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;

   // strobe-length checker, counted independently of the wait counter
   logic [CNT_W:0] chk_len;
   logic [CNT_W:0] exp_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    chk_len <= '0;
      else if (phase_q == PH_STROBE) chk_len <= chk_len + 1'b1;
      else                           chk_len <= '0;
   end

   assign exp_len = (CNT_W+1)'(int'(acc_cfg) * WS_STEP + 1);

   AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HOLD) |-> (chk_len == exp_len)); // R2
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready); // R9
   AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |=> ($stable(acc_addr) && $stable(acc_wdata) && $stable(acc_cfg))); // R10
   AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STROBE) |=> $stable(acc_cfg)); // R11
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 16,
   parameter bit WR_EARLY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  xbus_phase_e   phase,
   input  logic          acc_we,
   input  xbus_space_e   acc_space,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] acc_wdata,
   input  logic          wait_last,
   input  logic [DW-1:0] dq_i,
   output logic [AW-1:0] bus_addr,
   output logic          bus_prog_n,
   output logic          bus_data_n,
   output logic          bus_rd_n,
   output logic          bus_wr_n,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe,
   output logic [DW-1:0] rdata
);
   logic active;
   logic strobe;

   assign active     = (phase != PH_IDLE);
   assign strobe     = (phase == PH_STROBE);
   assign bus_addr   = acc_addr;
   assign bus_prog_n = !(active && (acc_space == SPACE_PROG));
   assign bus_data_n = !(active && (acc_space == SPACE_DATA));
   assign bus_rd_n   = !(strobe && !acc_we);
   assign bus_wr_n   = !(strobe && acc_we);
   assign dq_o       = acc_wdata;

   generate
      if (WR_EARLY) begin : g_drive_from_setup
         assign dq_oe = acc_we && active;
      end else begin : g_drive_from_strobe
         assign dq_oe = acc_we && (strobe || (phase == PH_HOLD));
      end
   endgenerate

   // capture on the edge where the read enable returns high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (strobe && !acc_we && wait_last) begin
         rdata <= dq_i;
      end
   end

   logic sel_low;
   assign sel_low = !bus_prog_n || !bus_data_n;

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n)); // R8
   AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_prog_n && !bus_data_n)); // R3
   AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_low |-> !dq_oe); // R7
   AST_RD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !dq_oe); // R5
   AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> dq_oe); // R6
   AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(sel_low)); // R4
   AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> sel_low); // R4
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_low && $past(sel_low)) |-> $stable(bus_addr)); // R4
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 16,
   parameter int CFG_W    = 2,
   parameter int WS_STEP  = 4,
   parameter bit WR_EARLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_ws,
   input  logic             core_req,
   input  logic             core_we,
   input  logic             core_space,
   input  logic [AW-1:0]    core_addr,
   input  logic [DW-1:0]    core_wdata,
   output logic             core_ready,
   output logic [DW-1:0]    core_rdata,
   output logic [AW-1:0]    bus_addr,
   output logic             bus_prog_n,
   output logic             bus_data_n,
   output logic             bus_rd_n,
   output logic             bus_wr_n,
   output logic [DW-1:0]    bus_dq_o,
   output logic             bus_dq_oe,
   input  logic [DW-1:0]    bus_dq_i
);
   localparam int MAX_WS = WS_STEP * ((1 << CFG_W) - 1);
   localparam int CNT_W  = (MAX_WS > 0) ? $clog2(MAX_WS + 1) : 1;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("xbus_ctrl: address and data widths must be positive");
      end
      if (CFG_W < 1 || CFG_W > 4) begin : g_bad_cfg
         $error("xbus_ctrl: CFG_W must be 1..4");
      end
      if (WS_STEP < 1) begin : g_bad_step
         $error("xbus_ctrl: WS_STEP must be positive");
      end
   endgenerate

   xbus_phase_e      phase;
   logic             acc_we;
   xbus_space_e      acc_space;
   logic [AW-1:0]    acc_addr;
   logic [DW-1:0]    acc_wdata;
   logic [CFG_W-1:0] acc_cfg;
   logic             wait_last;

   xbus_seq #(
      .AW(AW), .DW(DW), .CFG_W(CFG_W), .WS_STEP(WS_STEP), .CNT_W(CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (core_req),
      .we        (core_we),
      .space     (core_space),
      .addr      (core_addr),
      .wdata     (core_wdata),
      .cfg       (cfg_ws),
      .wait_last (wait_last),
      .phase     (phase),
      .acc_we    (acc_we),
      .acc_space (acc_space),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_cfg   (acc_cfg),
      .ready     (core_ready)
   );

   xbus_waitgen #(
      .CFG_W(CFG_W), .WS_STEP(WS_STEP), .CNT_W(CNT_W)
   ) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (phase == PH_SETUP),
      .step  (phase == PH_STROBE),
      .cfg   (acc_cfg),
      .last  (wait_last)
   );

   xbus_pins #(
      .AW(AW), .DW(DW), .WR_EARLY(WR_EARLY)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .acc_we     (acc_we),
      .acc_space  (acc_space),
      .acc_addr   (acc_addr),
      .acc_wdata  (acc_wdata),
      .wait_last  (wait_last),
      .dq_i       (bus_dq_i),
      .bus_addr   (bus_addr),
      .bus_prog_n (bus_prog_n),
      .bus_data_n (bus_data_n),
      .bus_rd_n   (bus_rd_n),
      .bus_wr_n   (bus_wr_n),
      .dq_o       (bus_dq_o),
      .dq_oe      (bus_dq_oe),
      .rdata      (core_rdata)
   );

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      core_ready |-> (bus_prog_n && bus_data_n && !bus_dq_oe)); // R9
endmodule

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_ws = '0;
   logic        core_req = 1'b0, core_we = 1'b0, core_space = 1'b0;
   logic [15:0] core_addr = '0, core_wdata = '0, bus_dq_i = '0;
   logic        core_ready, bus_prog_n, bus_data_n, bus_rd_n, bus_wr_n, bus_dq_oe;
   logic [15:0] core_rdata, bus_addr, bus_dq_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] last_rd = '0;

   always #5 clk = ~clk;

   xbus_ctrl u_xbus_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_ws(cfg_ws), .core_req(core_req),
      .core_we(core_we), .core_space(core_space), .core_addr(core_addr),
      .core_wdata(core_wdata), .core_ready(core_ready), .core_rdata(core_rdata),
      .bus_addr(bus_addr), .bus_prog_n(bus_prog_n), .bus_data_n(bus_data_n),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dq_o(bus_dq_o),
      .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
   );

   // {we, space, cfg[1:0], addr[15:0], wdata[15:0], pin_read_value[15:0]}
   localparam int NV = 8;
   localparam logic [51:0] VECS [NV] = '{
      {1'b0, 1'b1, 2'd0, 16'h0010, 16'h0000, 16'hA5A5},
      {1'b1, 1'b0, 2'd0, 16'h2001, 16'h1234, 16'h0000},
      {1'b0, 1'b0, 2'd1, 16'h8000, 16'h0000, 16'h5A0F},
      {1'b1, 1'b1, 2'd1, 16'hFFFE, 16'hBEEF, 16'h0000},
      {1'b0, 1'b1, 2'd2, 16'h0C3C, 16'h0000, 16'h0F0F},
      {1'b1, 1'b0, 2'd2, 16'h7777, 16'hC001, 16'h0000},
      {1'b0, 1'b0, 2'd3, 16'h4242, 16'h0000, 16'hFACE},
      {1'b1, 1'b1, 2'd3, 16'h1357, 16'h8421, 16'h0000}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // runs one access and checks every cycle; returns at the falling edge of the ready cycle
   task automatic run_access(input logic [51:0] v, input bit keep_req);
      logic        we, sp;
      logic [1:0]  cf;
      logic [15:0] ad, wd, rv;
      int          ws;
      logic [3:0]  sel_exp;
      we = v[51]; sp = v[50]; cf = v[49:48];
      ad = v[47:32]; wd = v[31:16]; rv = v[15:0];
      ws = int'(cf) * 4;
      @(negedge clk);
      core_req = 1'b1; core_we = we; core_space = sp; cfg_ws = cf;
      core_addr = ad; core_wdata = wd; bus_dq_i = rv;
      for (int k = 1; k <= 4 + ws; k++) begin
         @(negedge clk);
         sel_exp = {bus_prog_n, bus_data_n, bus_rd_n, bus_wr_n};
         if (k == 1) begin
            chk({bus_prog_n, bus_data_n} == {!sp, sp}, "R3 space select", {bus_prog_n, bus_data_n}, {!sp, sp});
            chk(bus_rd_n && bus_wr_n, "R4 setup enables high", sel_exp, 4'b0);
            chk(bus_addr == ad, "R4 setup address", bus_addr, ad);
            chk(bus_dq_oe == we, "R6 setup drive", bus_dq_oe, we);
            // perturb inputs mid-access: R10 and R11
            core_addr = ~ad; core_wdata = ~wd; cfg_ws = ~cf;
         end else if (k <= 2 + ws) begin
            chk({bus_rd_n, bus_wr_n} == {we, !we}, "R2 R8 strobe enables", {bus_rd_n, bus_wr_n}, {we, !we});
            chk(bus_addr == ad, "R10 address held", bus_addr, ad);
            chk(bus_dq_oe == we, "R5 R6 strobe drive", bus_dq_oe, we);
            if (we) chk(bus_dq_o == wd, "R6 strobe data", bus_dq_o, wd);
         end else if (k == 3 + ws) begin
            chk(bus_rd_n && bus_wr_n, "R2 R11 hold enables high", sel_exp, {!sp, sp, 2'b11});
            chk({bus_prog_n, bus_data_n} == {!sp, sp}, "R4 hold select", {bus_prog_n, bus_data_n}, {!sp, sp});
            chk(bus_addr == ad, "R4 hold address", bus_addr, ad);
            chk(bus_dq_oe == we, "R6 hold drive", bus_dq_oe, we);
            if (we) chk(bus_dq_o == wd, "R6 hold data", bus_dq_o, wd);
            chk(!core_ready, "R9 no early ready", core_ready, 0);
            bus_dq_i = ~rv;
         end else begin
            chk(core_ready, "R9 ready due", core_ready, 1);
            chk(bus_prog_n && bus_data_n, "R7 selects released", {bus_prog_n, bus_data_n}, 2'b11);
            chk(!bus_dq_oe, "R7 idle tri-state", bus_dq_oe, 0);
            if (!we) last_rd = rv;
            chk(core_rdata == last_rd, "R5 R9 read data", core_rdata, last_rd);
            if (!keep_req) core_req = 1'b0;
         end
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(bus_prog_n && bus_data_n && bus_rd_n && bus_wr_n, "R1 strobes high",
          {bus_prog_n, bus_data_n, bus_rd_n, bus_wr_n}, 4'hF);
      chk(!bus_dq_oe && !core_ready, "R1 oe and ready low", {bus_dq_oe, core_ready}, 0);
      chk(core_rdata == 16'h0, "R1 rdata cleared", core_rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(bus_prog_n && bus_data_n && !bus_dq_oe, "R7 idle after reset", {bus_prog_n, bus_data_n, bus_dq_oe}, 3'b110);

      for (int i = 0; i < NV; i++) run_access(VECS[i], 1'b0);

      // R10: request held through the ready cycle is taken one cycle later
      run_access(VECS[2], 1'b1);
      @(negedge clk);
      chk(bus_prog_n && bus_data_n, "R10 no accept during ready", {bus_prog_n, bus_data_n}, 2'b11);
      @(negedge clk);
      chk(!bus_data_n && bus_prog_n, "R10 held request starts", {bus_prog_n, bus_data_n}, 2'b10);
      chk(bus_addr == ~VECS[2][47:32], "R10 new address latched", bus_addr, ~VECS[2][47:32]);
      core_req = 1'b0;
      for (int w = 0; w < 40 && !core_ready; w++) @(negedge clk);
      chk(core_ready, "R9 held access completes", core_ready, 1);
      last_rd = bus_dq_i;
      chk(core_rdata == last_rd, "R5 held access data", core_rdata, last_rd);
      repeat (3) @(negedge clk);
      chk(bus_prog_n && bus_data_n && !core_ready, "R10 stays idle with no request",
          {bus_prog_n, bus_data_n, core_ready}, 3'b110);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule